// File: doc/BRIEF.md
# Peak Window Smoother with Overlap Feedback

This block turns a stream of raw clip samples into a smooth clip envelope for a crest factor reduction path. Each raw sample goes through a feedforward window filter of length `WIN_LEN`. Before that, an estimate of the clipping that recent peaks have already requested is subtracted from it. A second window filter, half as long, forms that estimate from the filter's own past inputs. This keeps two close peaks from being over-suppressed. The difference is clamped at zero before it enters the long filter.

A run-time bit selects the shape of both windows, linear (triangular) or parabolic (rounded). The window length is fixed when the block is built. A fixed-point scale factor is applied to the long filter's sum. Besides the envelope, the block exposes the filter input before and after clamping, and the feedback estimate, for debug. Coefficients are unsigned, with 1.0 equal to `2^(CW-1)`. Each registered output appears one clock after its accepted sample.

Top module: `peak_window_smoother`

## Requirements
- R1: After reset, or in the cycle after `sclr` is high, all outputs are zero and `out_valid` is low. The sample history is emptied, so the next sample is filtered as if every earlier input were zero. `sclr` overrides `in_valid`.
- R2: For each clock edge where `in_valid` is high and `sclr` is low, `out_valid` is high for exactly the following cycle, and the four data outputs belong to that sample.
- R3: The feedback output is `sum_{k=0}^{WIN_LEN/2-1} cb[k]*x[n-1-k]`, shifted right by `CW-1` and saturated to `2^(DW-1)-1`. Here `x` is the clamped filter input and `cb` is the half-length window. The current sample never feeds it.
- R4: `dbg_pre_clamp` (DW+1 bits, two's complement) equals the signed `raw_clip` minus the feedback output.
- R5: `dbg_ff_in` equals `dbg_pre_clamp` when that value is non-negative, and zero otherwise, including for negative `raw_clip`.
- R6: `smooth_clip` is `(sum_{k=0}^{WIN_LEN-1} cf[k]*x[n-k]) * SCALE`, shifted right by `2*(CW-1)` and saturated to `2^(DW-1)-1`.
- R7: With `win_sel`=0, tap k of an N-tap window is `floor(ONE*m/h)`, where h=N/2, m=min(k+1, N-k) and ONE=2^(CW-1).
- R8: With `win_sel`=1, tap k is `floor(ONE*(2*m*h - m*m)/(h*h))`, with the same h and m.
- R9: `win_sel` is taken at each accepted sample and applies to both windows for that sample. A change does not clear the history.
- R10: `smooth_clip` and `dbg_fb_out` never exceed `2^(DW-1)-1`. A long run of full-scale input drives `smooth_clip` to exactly that value.
- R11: Cycles with `in_valid` low leave the history untouched, keep `out_valid` low and hold all data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclr | input | 1 | Synchronous clear of history and outputs |
| in_valid | input | 1 | Raw clip sample present |
| raw_clip | input | DW | Raw clip sample, signed |
| win_sel | input | 1 | Window shape: 0 triangular, 1 rounded |
| out_valid | output | 1 | Outputs carry a new sample |
| smooth_clip | output | DW | Smoothed clip envelope |
| dbg_pre_clamp | output | DW+1 | Raw clip minus feedback, signed |
| dbg_ff_in | output | DW | Clamped long-filter input |
| dbg_fb_out | output | DW | Feedback filter output |

## Verification
A lone impulse followed by zeros shows the coefficient tables directly, one run per shape, since feedback clamps every later input to zero. Closely spaced peaks and a negative input drive the difference below zero, which separates the clamp and the feedback path from plain filtering. A stream that toggles the shape select shows that the history is kept across a change. Idle gaps, a mid-stream clear and a long full-scale run cover holding, flushing and saturation.

// File: rtl/pws_pkg.sv
package pws_pkg;

  // Tap value of an n-tap window; rounded selects the parabolic shape.
  function automatic int win_coef(input bit rounded, input int k, input int n, input int one);
    int h;
    int m;
    h = n / 2;
    m = (k + 1 < n - k) ? (k + 1) : (n - k);
    if (!rounded) return (one * m) / h;
    return (one * (2 * m * h - m * m)) / (h * h);
  endfunction

endpackage

// File: rtl/pws_coef_bank.sv
module pws_coef_bank #(
  parameter int N  = 16,
  parameter int CW = 12
) (
  input  logic            sel,
  output logic [N*CW-1:0] coef
);
  import pws_pkg::*;
  localparam int ONE = 1 << (CW - 1);

  for (genvar k = 0; k < N; k++) begin : g_tap
    localparam logic [CW-1:0] TRI = CW'(win_coef(1'b0, k, N, ONE));
    localparam logic [CW-1:0] RND = CW'(win_coef(1'b1, k, N, ONE));
    assign coef[k*CW +: CW] = sel ? RND : TRI;
  end
endmodule

// File: rtl/pws_dot.sv
module pws_dot #(
  parameter int N  = 16,
  parameter int XW = 15,
  parameter int CW = 12,
  parameter int AW = XW + CW + $clog2(N)
) (
  input  logic [N*XW-1:0] xv,
  input  logic [N*CW-1:0] cv,
  output logic [AW-1:0]   acc
);
  always_comb begin
    acc = '0;
    for (int k = 0; k < N; k++) begin
      acc = acc + AW'(xv[k*XW +: XW]) * AW'(cv[k*CW +: CW]);
    end
  end
endmodule

// File: rtl/pws_history.sv
module pws_history #(
  parameter int DEPTH = 15,
  parameter int W     = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] taps
);
  logic [DEPTH*W-1:0] q, d;

  always_comb begin
    d = q;
    if (clr)     d = '0;
    else if (en) d = {q[(DEPTH-1)*W-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign taps = q;
endmodule

// File: rtl/peak_window_smoother.sv
module peak_window_smoother #(
  parameter int DW      = 16,
  parameter int CW      = 12,
  parameter int WIN_LEN = 16,
  parameter int SCALE   = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclr,
  input  logic          in_valid,
  input  logic [DW-1:0] raw_clip,
  input  logic          win_sel,
  output logic          out_valid,
  output logic [DW-1:0] smooth_clip,
  output logic [DW:0]   dbg_pre_clamp,
  output logic [DW-1:0] dbg_ff_in,
  output logic [DW-1:0] dbg_fb_out
);
  localparam int XW     = DW - 1;
  localparam int FB_LEN = WIN_LEN / 2;
  localparam int HIST   = WIN_LEN - 1;
  localparam int SH     = CW - 1;
  localparam int AFF    = XW + CW + $clog2(WIN_LEN);
  localparam int AFB    = XW + CW + $clog2(FB_LEN);
  localparam int ASC    = AFF + CW;
  localparam logic [XW-1:0]  XMAX   = {XW{1'b1}};
  localparam logic [AFB-1:0] XMAX_B = AFB'(XMAX);
  localparam logic [ASC-1:0] XMAX_S = ASC'(XMAX);

  logic [HIST*XW-1:0]    hist_taps;
  logic [WIN_LEN*CW-1:0] cff;
  logic [FB_LEN*CW-1:0]  cfb;
  logic [AFB-1:0]        fb_acc, fb_shift;
  logic [AFF-1:0]        ff_acc;
  logic [ASC-1:0]        scaled, sm_shift;
  logic [XW-1:0]         fb_val, x_new, sm_val;
  logic [DW:0]           pre;

  pws_coef_bank #(.N(WIN_LEN), .CW(CW)) u_cff (.sel(win_sel), .coef(cff));
  pws_coef_bank #(.N(FB_LEN),  .CW(CW)) u_cfb (.sel(win_sel), .coef(cfb));

  // Feedback sees only already-accepted samples (history taps 0..FB_LEN-1).
  pws_dot #(.N(FB_LEN), .XW(XW), .CW(CW), .AW(AFB)) u_fb (
    .xv (hist_taps[FB_LEN*XW-1:0]),
    .cv (cfb),
    .acc(fb_acc)
  );

  always_comb begin
    fb_shift = fb_acc >> SH;
    fb_val   = (fb_shift > XMAX_B) ? XMAX : fb_shift[XW-1:0];
    pre      = {raw_clip[DW-1], raw_clip} - {2'b00, fb_val};
    x_new    = pre[DW] ? '0 : pre[XW-1:0];
  end

  pws_dot #(.N(WIN_LEN), .XW(XW), .CW(CW), .AW(AFF)) u_ff (
    .xv ({hist_taps, x_new}),
    .cv (cff),
    .acc(ff_acc)
  );

  always_comb begin
    scaled   = ASC'(ff_acc) * ASC'(SCALE);
    sm_shift = scaled >> (2 * SH);
    sm_val   = (sm_shift > XMAX_S) ? XMAX : sm_shift[XW-1:0];
  end

  pws_history #(.DEPTH(HIST), .W(XW)) u_hist (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (sclr),
    .en   (in_valid),
    .din  (x_new),
    .taps (hist_taps)
  );

  logic          vld_d;
  logic [DW-1:0] sm_d, ffin_d, fb_d;
  logic [DW:0]   pre_d;

  always_comb begin
    vld_d  = 1'b0;
    sm_d   = smooth_clip;
    pre_d  = dbg_pre_clamp;
    ffin_d = dbg_ff_in;
    fb_d   = dbg_fb_out;
    if (sclr) begin
      sm_d   = '0;
      pre_d  = '0;
      ffin_d = '0;
      fb_d   = '0;
    end else if (in_valid) begin
      vld_d  = 1'b1;
      sm_d   = {1'b0, sm_val};
      pre_d  = pre;
      ffin_d = {1'b0, x_new};
      fb_d   = {1'b0, fb_val};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      smooth_clip   <= '0;
      dbg_pre_clamp <= '0;
      dbg_ff_in     <= '0;
      dbg_fb_out    <= '0;
    end else begin
      out_valid     <= vld_d;
      smooth_clip   <= sm_d;
      dbg_pre_clamp <= pre_d;
      dbg_ff_in     <= ffin_d;
      dbg_fb_out    <= fb_d;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sclr |=> (!out_valid && smooth_clip == '0 && dbg_ff_in == '0 && dbg_fb_out == '0)); // R1
  AST_ONE_CYCLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sclr) |=> out_valid); // R2
  AST_PRE_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(dbg_pre_clamp) ==
      $signed({$past(raw_clip[DW-1]), $past(raw_clip)}) - $signed({1'b0, dbg_fb_out}))); // R4
  AST_CLAMP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dbg_pre_clamp[DW] ? (dbg_ff_in == '0)
                                     : (dbg_ff_in == dbg_pre_clamp[DW-1:0]))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!smooth_clip[DW-1] && !dbg_fb_out[DW-1])); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !sclr) |=> (!out_valid && $stable(smooth_clip) && $stable(dbg_fb_out))); // R11
endmodule

// File: tb/peak_window_smoother_test.sv
`timescale 1ns/1ps
module peak_window_smoother_test;
  localparam int DW = 16, CW = 12, WL = 16, SC = 2048;
  localparam int H  = WL / 2;
  localparam longint ONE  = 64'd1 << (CW - 1);
  localparam longint XMAX = (64'd1 << (DW - 1)) - 1;

  logic clk = 0, rst_n = 0, sclr = 0, in_valid = 0, win_sel = 0;
  logic [DW-1:0] raw_clip = '0;
  logic out_valid;
  logic [DW-1:0] smooth_clip, dbg_ff_in, dbg_fb_out;
  logic [DW:0] dbg_pre_clamp;

  int checks = 0, failures = 0;
  bit done = 0, saw_neg = 0, saw_sat = 0;
  longint mh [WL-1];

  always #4 clk = ~clk;

  peak_window_smoother #(.DW(DW), .CW(CW), .WIN_LEN(WL), .SCALE(SC)) uut (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .in_valid(in_valid), .raw_clip(raw_clip),
    .win_sel(win_sel), .out_valid(out_valid), .smooth_clip(smooth_clip),
    .dbg_pre_clamp(dbg_pre_clamp), .dbg_ff_in(dbg_ff_in), .dbg_fb_out(dbg_fb_out));

  function automatic longint wc(input bit rnd, input int k, input int n);
    longint h = n / 2;
    longint m = (k + 1 < n - k) ? k + 1 : n - k;
    return rnd ? (ONE * (2 * m * h - m * m)) / (h * h) : (ONE * m) / h;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < WL - 1; i++) mh[i] = 0;
  endtask

  // Drives one sample at a falling edge, checks all outputs one edge later.
  task automatic send(input int r, input bit sel, input string tag);
    longint fb = 0, pre, x, ff, sm;
    raw_clip = DW'(r); win_sel = sel; in_valid = 1;
    for (int k = 0; k < H; k++) fb += wc(sel, k, H) * mh[k];
    fb = fb >>> (CW - 1);
    if (fb > XMAX) fb = XMAX;
    pre = r - fb;
    if (pre < 0) saw_neg = 1;
    x = (pre < 0) ? 0 : pre;
    ff = wc(sel, 0, WL) * x;
    for (int k = 1; k < WL; k++) ff += wc(sel, k, WL) * mh[k-1];
    sm = (ff * SC) >>> (2 * (CW - 1));
    if (sm > XMAX) sm = XMAX;
    for (int i = WL - 2; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = x;
    @(negedge clk);
    chk("R2", "out_valid", out_valid, 1);
    chk({"R3 ", tag}, "fb", dbg_fb_out, fb);
    chk({"R4 ", tag}, "pre", $signed(dbg_pre_clamp), pre);
    chk({"R5 ", tag}, "ff_in", dbg_ff_in, x);
    chk({"R6 ", tag}, "smooth", smooth_clip, sm);
    if (longint'(smooth_clip) == XMAX) saw_sat = 1;
  endtask

  task automatic idle(input int n);
    logic [DW-1:0] hold_s = smooth_clip, hold_f = dbg_fb_out;
    in_valid = 0; raw_clip = DW'(12345);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R11", "out_valid idle", out_valid, 0);
      chk("R11", "smooth hold", smooth_clip, hold_s);
      chk("R11", "fb hold", dbg_fb_out, hold_f);
    end
  endtask

  task automatic do_clear();
    in_valid = 1; sclr = 1; raw_clip = DW'(9000);
    @(negedge clk);
    sclr = 0; in_valid = 0;
    chk("R1", "out_valid after clear", out_valid, 0);
    chk("R1", "smooth after clear", smooth_clip, 0);
    chk("R1", "ff_in after clear", dbg_ff_in, 0);
    model_clear();
  endtask

  task automatic t_reset();
    chk("R1", "out_valid reset", out_valid, 0);
    chk("R1", "smooth reset", smooth_clip, 0);
    chk("R1", "pre reset", dbg_pre_clamp, 0);
    chk("R1", "fb reset", dbg_fb_out, 0);
  endtask

  task automatic t_impulse(input bit sel, input string tag);
    do_clear();
    send(20000, sel, tag);
    for (int i = 0; i < WL + 1; i++) send(0, sel, tag);
  endtask

  task automatic t_close_peaks();
    do_clear(); saw_neg = 0;
    send(20000, 0, "R3"); send(18000, 0, "R3"); send(3000, 0, "R3");
    send(25000, 0, "R3"); send(0, 0, "R3"); send(24000, 0, "R3");
    send(-5000, 0, "R5");
    chk("R5", "negative difference seen", saw_neg, 1);
  endtask

  task automatic t_switch();
    do_clear();
    for (int i = 0; i < 24; i++) send(6000 + 700 * i, bit'((i / 3) % 2), "R9");
  endtask

  task automatic t_idle();
    send(15000, 1, "R11"); idle(3); send(14000, 1, "R11"); idle(2); send(9000, 0, "R11");
  endtask

  task automatic t_midclear();
    send(30000, 0, "R1"); send(30000, 0, "R1");
    do_clear();
    send(10000, 0, "R1");
  endtask

  task automatic t_saturate();
    do_clear(); saw_sat = 0;
    for (int i = 0; i < 40; i++) send(32767, i >= 20, "R10");
    chk("R10", "smooth reached full scale", saw_sat, 1);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_impulse(0, "R7");
    t_impulse(1, "R8");
    t_close_peaks();
    t_switch();
    t_idle();
    t_midclear();
    t_saturate();
    in_valid = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule